// File: doc/BRIEF.md
# Step Attenuator Serial Programming Sequencer

This block is a host-side master that loads a 6-bit attenuation setting into a serially programmed step attenuator. It runs from a fast system clock and produces three slow control lines: a serial clock, a serial data line and a latch enable. A requested code, in 0.5 dB units from 0 to 63, is captured on a start strobe. The code is shifted out most significant bit first while the latch enable stays low. The latch enable is then pulsed high and returned low, which transfers the word into the attenuator.

Every timing interval is a parameter counted in system clock cycles. These intervals are the serial clock high time and low time, the data hold and setup, the delay from the last falling clock edge to latch enable, and the latch pulse width. An elaboration-time check stops the build if any parameter set cannot meet the device minima at the stated system clock period. The minima are: 30 ns for each clock phase, a 100 ns clock period (10 MHz maximum), 10 ns for data setup and hold, 10 ns from the last fall to latch, and 30 ns of latch pulse.

A controller raises `start_i` with a code and waits for `done_o`, or for `busy_o` to fall.

Top module: `atten_prog_seq`

## Requirements
- R1: The code bits go out in order from bit 5 (16 dB) down to bit 0 (0.5 dB). Code bit n is the line value for weight 0.5*2^n dB, with 1 meaning that stage is inserted.
- R2: The latch enable stays low for the whole time the serial clock runs, and it is never high while the serial clock is high.
- R3: For each bit, the serial clock is low for LOW_CYC cycles and then high for HIGH_CYC cycles. The clock idles low.
- R4: Serial data changes only while the serial clock is low, on both sides of the change. Each bit appears HOLD_CYC cycles after the preceding falling edge and stays fixed until that bit's falling edge.
- R5: The latch enable rises exactly LESU_CYC cycles after the sixth falling edge of the serial clock.
- R6: The latch enable stays high for exactly LEPW_CYC cycles.
- R7: `done_o` is high for exactly one cycle, beginning at the edge where the latch enable returns low.
- R8: `busy_o` rises at the edge that accepts a start and falls one cycle after `done_o`. A start strobe while busy is ignored. The code is taken from `code_i` only at acceptance, so later changes to `code_i` do not affect the word in flight.
- R9: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to program `code_i`; accepted only when idle |
| code_i | input | 6 | Attenuation in 0.5 dB units |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ser_clk_o | output | 1 | Serial clock to the attenuator |
| ser_data_o | output | 1 | Serial data to the attenuator |
| latch_en_o | output | 1 | Latch enable to the attenuator |

## Verification
The bench exercises the following cases:
- All-zero and all-one codes, single-bit codes at each end of the word, and alternating patterns. A design that reverses the bit order or drops the last bit would show the wrong value on the data line during a specific high phase.
- A second start during a transfer, and a code change during a transfer. A design that restarts or recaptures would change the data stream partway through.
- A start held high across the end of a transfer. The next word must begin only after `busy_o` has fallen.
- Comparing every cycle against the model. An off-by-one in any phase counter, or data switching on the clock edge instead of after the hold interval, shows up as a mismatch on the exact cycle where it occurs.

// File: rtl/atten_seq_pkg.sv
package atten_seq_pkg;

    localparam int IDX_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOW   = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LESU  = 3'd3,
        ST_PULSE = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e       state;
        logic             sclk;
        logic             sdata;
        logic             le;
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] bit_idx;
    } seq_regs_t;

endpackage

// File: rtl/aps_phase_timer.sv
module aps_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/aps_word_shifter.sv
module aps_word_shifter #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             shift_i,
    output logic             msb_o
);

    logic [WIDTH-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) begin
            word_d = word_i;
        end else if (shift_i) begin
            word_d = {word_q[WIDTH-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign msb_o = word_q[WIDTH-1];

    // R1
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (msb_o == $past(word_q[WIDTH-2])));

endmodule

// File: rtl/atten_prog_seq.sv
module atten_prog_seq
    import atten_seq_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int PERIOD_PS = 8000,
    parameter int HIGH_CYC  = 5,
    parameter int LOW_CYC   = 8,
    parameter int HOLD_CYC  = 2,
    parameter int SETUP_CYC = 2,
    parameter int LESU_CYC  = 2,
    parameter int LEPW_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ser_clk_o,
    output logic              ser_data_o,
    output logic              latch_en_o
);

    localparam int MAX_AB  = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
    localparam int MAX_CD  = (LESU_CYC > LEPW_CYC) ? LESU_CYC : LEPW_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam bit TIMING_OK =
        (HIGH_CYC * PERIOD_PS >= 30000) &&
        (LOW_CYC  * PERIOD_PS >= 30000) &&
        ((HIGH_CYC + LOW_CYC) * PERIOD_PS >= 100000) &&
        (HOLD_CYC >= 1) && (HOLD_CYC * PERIOD_PS >= 10000) &&
        (SETUP_CYC * PERIOD_PS >= 10000) &&
        (LOW_CYC >= HOLD_CYC + SETUP_CYC) &&
        (LESU_CYC >= 1) && (LESU_CYC * PERIOD_PS >= 10000) &&
        (LEPW_CYC >= 1) && (LEPW_CYC * PERIOD_PS >= 30000) &&
        (LESU_CYC + LEPW_CYC + 1 >= HOLD_CYC) &&
        (CODE_W >= 2) && (CODE_W < 256);

    initial begin : param_guard
        timing_param_chk: assert (TIMING_OK)
            else $fatal(1, "atten_prog_seq: timing parameters violate device minima");
    end

    seq_regs_t        cur_q, nxt_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_zero;
    logic             sr_load;
    logic             sr_shift;
    logic             sr_msb;

    aps_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .cnt_o      (tmr_cnt),
        .zero_o     (tmr_zero)
    );

    aps_word_shifter #(.WIDTH(CODE_W)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sr_load),
        .word_i  (code_i),
        .shift_i (sr_shift),
        .msb_o   (sr_msb)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sr_load  = 1'b0;
        sr_shift = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                nxt_d.sdata = 1'b0;
                if (start_i) begin
                    sr_load       = 1'b1;
                    nxt_d.busy    = 1'b1;
                    nxt_d.bit_idx = '0;
                    nxt_d.state   = ST_LOW;
                    tmr_load      = 1'b1;
                    tmr_val       = CNT_W'(LOW_CYC);
                end
            end
            ST_LOW: begin
                if (tmr_cnt == CNT_W'(LOW_CYC - HOLD_CYC)) begin
                    nxt_d.sdata = sr_msb;
                    sr_shift    = 1'b1;
                end
                if (tmr_zero) begin
                    nxt_d.sclk  = 1'b1;
                    nxt_d.state = ST_HIGH;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(HIGH_CYC);
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    nxt_d.sclk = 1'b0;
                    tmr_load   = 1'b1;
                    if (cur_q.bit_idx == IDX_W'(CODE_W - 1)) begin
                        nxt_d.state = ST_LESU;
                        tmr_val     = CNT_W'(LESU_CYC);
                    end else begin
                        nxt_d.state   = ST_LOW;
                        nxt_d.bit_idx = cur_q.bit_idx + IDX_W'(1);
                        tmr_val       = CNT_W'(LOW_CYC);
                    end
                end
            end
            ST_LESU: begin
                if (tmr_zero) begin
                    nxt_d.le    = 1'b1;
                    nxt_d.state = ST_PULSE;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(LEPW_CYC);
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    nxt_d.le    = 1'b0;
                    nxt_d.done  = 1'b1;
                    nxt_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                nxt_d.busy  = 1'b0;
                nxt_d.sdata = 1'b0;
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy_o     = cur_q.busy;
    assign done_o     = cur_q.done;
    assign ser_clk_o  = cur_q.sclk;
    assign ser_data_o = cur_q.sdata;
    assign latch_en_o = cur_q.le;

    // R2
    le_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_clk_o && latch_en_o));

    // R2
    le_idle_during_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> (!latch_en_o && busy_o));

    // R4
    data_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data_o) |-> (!ser_clk_o && !$past(ser_clk_o)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_on_le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_en_o) |-> done_o);

    // R8
    busy_ends_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

endmodule

// File: tb/atten_prog_seq_bench.sv
module atten_prog_seq_bench;

    localparam int HIGH  = 5;
    localparam int LOW   = 8;
    localparam int HOLD  = 2;
    localparam int SETUP = 2;
    localparam int LESU  = 2;
    localparam int LEPW  = 4;
    localparam int NBIT  = 6;
    localparam int PER   = HIGH + LOW;
    localparam int LAST  = NBIT * PER + LESU + LEPW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] code = '0;
    logic       busy, done, sclk, sdata, le;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    bit active = 1'b0;
    int t = 0;
    bit bits_q[$];

    always #4 clk = ~clk;

    atten_prog_seq #(
        .CODE_W(6), .PERIOD_PS(8000), .HIGH_CYC(HIGH), .LOW_CYC(LOW),
        .HOLD_CYC(HOLD), .SETUP_CYC(SETUP), .LESU_CYC(LESU), .LEPW_CYC(LEPW)
    ) u_atten_prog_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code),
        .busy_o(busy), .done_o(done), .ser_clk_o(sclk),
        .ser_data_o(sdata), .latch_en_o(le)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d (t=%0d): actual %0d expected %0d",
                     req, what, cycles, t, act, exp);
        end
    endtask

    // Reference model: advances at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active = 1'b0;
            t = 0;
        end else if (active) begin
            t++;
            if (t > LAST) active = 1'b0;
        end else if (start) begin
            active = 1'b1;
            t = 0;
            bits_q.delete();
            for (int i = NBIT - 1; i >= 0; i--) bits_q.push_back(code[i]);
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        int e_sclk, e_data, e_le, e_done, e_busy;
        cycles++;
        e_sclk = 0; e_data = 0; e_le = 0; e_done = 0; e_busy = 0;
        if (!rst_n) begin
            // R9
            chk("R9", "reset outputs", {busy, done, sclk, sdata, le}, 0);
        end else begin
            if (active) begin
                e_busy = 1;
                if (t < NBIT * PER) begin
                    int k, r;
                    k = t / PER;
                    r = t % PER;
                    e_sclk = (r >= LOW) ? 1 : 0;
                    if (r >= HOLD) e_data = bits_q[k];
                    else           e_data = (k == 0) ? 0 : bits_q[k-1];
                end else begin
                    e_data = bits_q[NBIT-1];
                end
                e_le   = (t >= NBIT * PER + LESU && t < LAST) ? 1 : 0;
                e_done = (t == LAST) ? 1 : 0;
            end
            chk("R3", "ser_clk", sclk, e_sclk);
            chk("R1/R4", "ser_data", sdata, e_data);
            chk("R2/R5/R6", "latch_en", le, e_le);
            chk("R7", "done", done, e_done);
            chk("R8", "busy", busy, e_busy);
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_word(input logic [5:0] c);
        @(negedge clk);
        code  = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        code  = ~c;
        wait_neg(LAST + 3);
    endtask

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        run_word(6'h20);   // R1 only 16 dB stage
        run_word(6'h01);   // R1 only 0.5 dB stage
        run_word(6'h00);
        run_word(6'h3F);
        run_word(6'h2A);
        run_word(6'h15);
        // R8: start while busy with a different code is ignored
        @(negedge clk);
        code = 6'h33; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_neg(20);
        code = 6'h0C; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_neg(LAST + 3);
        // R8: start held high across the end of a transfer
        @(negedge clk);
        code = 6'h27; start = 1'b1;
        wait_neg(LAST + 5);
        start = 1'b0;
        wait_neg(2 * LAST + 6);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 20000", cycles);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule